// File: doc/BRIEF.md
# Burst-Mode Laser Gate for 66-bit Upstream Blocks

This block sits on a burst-mode upstream transmit path, after the forward-error-correction encoder. At that point in the path it sees every 66-bit block that will go onto the fibre, parity blocks included. It sorts each block into idle or non-idle. From that it drives a laser enable, and it delays the data stream so that the laser is already lit when the first meaningful block reaches the optics.

Each codeword carries 29 payload slots followed by its parity blocks. A burst's last frame can end in any payload slot, and idles fill the rest of that codeword's payload. Parity blocks count as activity, so the laser stays lit until the final parity block has left, and then for a programmable hold time.

While the laser warms up, the idle blocks that lead the burst out of the delay line are overwritten with a programmable synchronization pattern. This gives the receiver something to settle gain, clock recovery and block lock on. The substitution uses the same 66-bit path as all other blocks. The idle directly in front of the first non-idle block is always left intact, so a start character is never left without a preceding idle.

Top module: `burst_laser_gate`

## Requirements
- R1: A block is idle only when bits [65:64] are 2'b10, bits [63:56] are 8'h1E and bits [55:0] are all zero (eight 7-bit idle control codes of 7'h00). Any other block presented with in_valid high, including one that differs from this in a single bit, is non-idle.
- R2: out_valid and out_block, as seen after clock edge t, equal in_valid and in_block sampled at edge t-LEAD_BLOCKS, except where R6 applies.
- R3: laser_on is high in the cycle after any edge at which a valid non-idle block is sampled.
- R4: Parity blocks are ordinary non-idle blocks. laser_on stays high until LEAD_BLOCKS+OFF_HOLD+1 edges after the last valid non-idle input, then falls. A valid non-idle block never appears at the output while laser_on is low.
- R5: A non-idle block arriving while the hold time is running keeps laser_on high with no gap and no sync-pattern substitution.
- R6: Suppose the first non-idle block of a burst is sampled at edge f while laser_on is low. Then every valid idle block sampled at edges f-LEAD_BLOCKS+1 through f-2 leaves the output as SYNC_PATTERN.
- R7: In the case of R6, the idle block sampled at edge f-1 leaves the output unchanged.
- R8: A cycle with in_valid low neither turns the laser on nor is replaced by the sync pattern, whatever in_block holds.
- R9: After synchronous reset, laser_on and out_valid are low and out_block holds the idle block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one 66-bit block per cycle |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input slot carries a block |
| in_block | input | 66 | Input block, sync header in [65:64] |
| out_valid | output | 1 | Delayed in_valid |
| out_block | output | 66 | Delayed block, with leading idles replaced by the sync pattern |
| laser_on | output | 1 | Laser enable |

## Verification
On every cycle, the assertions check four things. A valid non-idle input lights the laser on the next cycle. An unlit laser with no valid non-idle input stays dark. No non-idle block or sync pattern leaves while the laser is dark. The laser stays lit for the full hold window after the last non-idle output. The exact delay, the start and end of the substitution window, the preserved idle before the burst's first block, and the exact edge at which the laser falls need whole scenarios. The bench covers these with a burst whose frame ends early in its codeword before parity, a bubble-laden lead-in, near-idle blocks, and a retrigger during the hold time. It compares every output cycle against a model derived from these requirements.

// File: rtl/burst_laser_gate.sv
`timescale 1ns/1ps
module burst_laser_gate #(
  parameter int          LEAD_BLOCKS  = 16,
  parameter int          OFF_HOLD     = 32,
  parameter logic [65:0] SYNC_PATTERN = {2'b01, 64'hD5D5_A3A3_5C5C_2B2B}
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [65:0] in_block,
  output logic        out_valid,
  output logic [65:0] out_block,
  output logic        laser_on
);
  localparam int          L        = LEAD_BLOCKS;
  localparam int          HOLD_W   = $clog2(OFF_HOLD + 2);
  localparam logic [65:0] IDLE_BLK = {2'b10, 8'h1E, 56'd0};

  logic [65:0]       dl_blk [L];
  logic [L-1:0]      dl_vld;
  logic [L-1:0]      dl_act;
  logic [HOLD_W-1:0] hold_cnt;
  logic              lead;

  wire in_act   = in_valid && (in_block != IDLE_BLK);
  wire tail_act = dl_act[L-1];
  wire sub_sel  = lead && dl_vld[L-1] && !tail_act && !dl_act[L-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < L; i++) dl_blk[i] <= IDLE_BLK;
      dl_vld    <= '0;
      dl_act    <= '0;
      out_valid <= 1'b0;
      out_block <= IDLE_BLK;
      laser_on  <= 1'b0;
      hold_cnt  <= '0;
      lead      <= 1'b0;
    end else begin
      dl_blk[0] <= in_block;
      for (int i = 1; i < L; i++) dl_blk[i] <= dl_blk[i-1];
      dl_vld    <= {dl_vld[L-2:0], in_valid};
      dl_act    <= {dl_act[L-2:0], in_act};
      out_valid <= dl_vld[L-1];
      out_block <= sub_sel ? SYNC_PATTERN : dl_blk[L-1];

      if (in_act || (|dl_act)) begin
        laser_on <= 1'b1;
        hold_cnt <= HOLD_W'(OFF_HOLD);
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
      end else begin
        laser_on <= 1'b0;
      end

      if (in_act && !laser_on) lead <= 1'b1;
      else if (tail_act)       lead <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_laser_gate_chk.sv
`timescale 1ns/1ps
module burst_laser_gate_chk #(
  parameter int          OFF_HOLD     = 32,
  parameter logic [65:0] SYNC_PATTERN = {2'b01, 64'hD5D5_A3A3_5C5C_2B2B}
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [65:0] in_block,
  input logic        out_valid,
  input logic [65:0] out_block,
  input logic        laser_on
);
  localparam logic [65:0] IDLE_BLK = {2'b10, 8'h1E, 56'd0};

  wire in_busy  = in_valid && (in_block != IDLE_BLK);
  wire out_busy = out_valid && (out_block != IDLE_BLK);
  int  since_out;

  always_ff @(posedge clk) begin
    if (rst)                                      since_out <= 0;
    else if (out_busy)                            since_out <= 1;
    else if (since_out != 0 && since_out < OFF_HOLD) since_out <= since_out + 1;
    else                                          since_out <= 0;
  end

  AST_LIGHT_ON_INPUT: assert property (@(posedge clk) disable iff (rst) in_busy |=> laser_on); // R3
  AST_NO_DARK_DATA:   assert property (@(posedge clk) disable iff (rst) out_busy |-> laser_on); // R4
  AST_HOLD_WINDOW:    assert property (@(posedge clk) disable iff (rst) (since_out != 0 && since_out <= OFF_HOLD) |-> laser_on); // R4
  AST_SYNC_LIT:       assert property (@(posedge clk) disable iff (rst) (out_valid && out_block == SYNC_PATTERN) |-> laser_on); // R6
  AST_DARK_STAYS:     assert property (@(posedge clk) disable iff (rst) (!laser_on && !in_busy) |=> !laser_on); // R8
endmodule

bind burst_laser_gate burst_laser_gate_chk #(.OFF_HOLD(OFF_HOLD), .SYNC_PATTERN(SYNC_PATTERN)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_block(in_block),
  .out_valid(out_valid), .out_block(out_block), .laser_on(laser_on)
);

// File: tb/burst_laser_gate_tb_top.sv
`timescale 1ns/1ps
module burst_laser_gate_tb_top;
  localparam int          L    = 8;
  localparam int          H    = 6;
  localparam int          N    = 400;
  localparam logic [65:0] IDLE = {2'b10, 8'h1E, 56'd0};
  localparam logic [65:0] SYNC = {2'b01, 64'hD5D5_A3A3_5C5C_2B2B};

  typedef struct packed { logic v; logic [65:0] b; logic las; int idx; } exp_t;

  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [65:0] in_block = IDLE;
  logic out_valid, laser_on;
  logic [65:0] out_block;
  logic        stim_v [N];
  logic [65:0] stim_b [N];
  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_laser_gate #(.LEAD_BLOCKS(L), .OFF_HOLD(H), .SYNC_PATTERN(SYNC)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_block(in_block),
    .out_valid(out_valid), .out_block(out_block), .laser_on(laser_on));

  function automatic bit act(int i);
    return i >= 0 && i < N && stim_v[i] && stim_b[i] != IDLE;
  endfunction
  function automatic bit las_exp(int t);
    for (int j = t; j >= 0 && j >= t - L - H; j--) if (act(j)) return 1;
    return 0;
  endfunction
  function automatic bit starts(int f);
    return act(f) && (f == 0 || !las_exp(f - 1));
  endfunction
  function automatic bit sub_exp(int i);
    if (!stim_v[i] || act(i)) return 0;
    for (int f = i + 2; f <= i + L - 1; f++) if (starts(f)) return 1;
    return 0;
  endfunction

  task automatic chk(string tag, int idx, logic [65:0] a, logic [65:0] e);
    n_cmp++;
    if (a !== e) begin
      n_bad++;
      $display("FAIL %s idx %0d actual %h expected %h", tag, idx, a, e);
    end
  endtask

  task automatic drive(int t);
    exp_t e;
    @(negedge clk);
    rst      = 1'b0;
    in_valid = stim_v[t];
    in_block = stim_b[t];
    e.idx = t;
    e.las = las_exp(t);
    if (t < L) begin e.v = 1'b0; e.b = IDLE; end
    else begin
      e.v = stim_v[t-L];
      e.b = sub_exp(t-L) ? SYNC : stim_b[t-L];
    end
    q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        string dtag, ltag;
        int i;
        e = q.pop_front();
        i = e.idx - L;
        dtag = (i >= 0 && sub_exp(i)) ? "R6" : (i >= 0 && starts(i + 1) && stim_v[i]) ? "R7" : "R2";
        ltag = (e.idx >= 100 && e.idx < 130) ? "R8" : (e.idx >= 130 && e.idx < 160) ? "R1" :
               (e.idx >= 160 && e.idx < 200) ? "R5" : (e.idx >= 20 && e.idx < 28) ? "R3" : "R4";
        chk(dtag, e.idx, 66'(out_valid), 66'(e.v));
        chk(dtag, e.idx, out_block, e.b);
        chk(ltag, e.idx, 66'(laser_on), 66'(e.las));
      end
    end
  end

  initial begin : watchdog
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < N; i++) begin stim_v[i] = 1'b1; stim_b[i] = IDLE; end
    // Burst 1: frame ends at payload slot 10 of 29, idles fill, then 4 parity blocks (R4, R6, R7)
    stim_b[20] = {2'b10, 8'h78, 56'h0011_2233_4455_66};
    for (int i = 21; i < 30; i++) stim_b[i] = {2'b01, 64'(i) * 64'h0101_0101_0101_0101};
    for (int i = 49; i < 53; i++) stim_b[i] = {2'b01, 64'hFEED_0000_0000_0000 | 64'(i)};
    // Bubbles, one holding non-idle data (R8), one inside the lead-in window
    stim_v[102] = 1'b0; stim_v[105] = 1'b0; stim_v[125] = 1'b0;
    stim_v[110] = 1'b0; stim_b[110] = {2'b01, 64'h1234_5678_9ABC_DEF0};
    // Burst 2: near-idle blocks count as activity (R1)
    stim_b[130] = {2'b10, 8'h1E, 56'd1};
    stim_b[136] = {2'b01, 8'h1E, 56'd0};
    // Burst 3: retrigger while holding (R5)
    stim_b[160] = {2'b10, 8'h78, 56'hAB};
    stim_b[172] = {2'b01, 64'hCAFE};
    for (int i = 250; i < 262; i++) stim_b[i] = {2'b01, 64'hBEEF_0000 + 64'(i)};

    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9", -1, 66'(laser_on), 66'd0);
    chk("R9", -1, 66'(out_valid), 66'd0);
    chk("R9", -1, out_block, IDLE);
    for (int t = 0; t < N; t++) drive(t);
    @(negedge clk); in_valid = 1'b0; in_block = IDLE;
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule